// File: doc/BRIEF.md
# Wide-Word Dual-Port Bridge Memory

This block is a storage array reached from two sides at once. A user port reads and writes whole words of a configurable width `WIDTH` at a configurable depth `DEPTH`. A host-facing 16-bit register bus reaches the same contents one 16-bit piece at a time. Inside, the wide word is cut into `ceil(WIDTH/16)` slices. Each slice lives in its own narrow memory, so a single user location appears on the bus as several addresses that lie `DEPTH` apart.

The bus window begins at the parameter `BASE`. All of slice 0 comes first, then all of slice 1, and so on. When `WIDTH` is not a multiple of 16, the last slice is narrower than 16 bits. A build-time mode parameter can make either side write-only or read-only. Every location reads as zero after reset, whether or not it has been written.

Top module: `bridge_mem`

## Requirements
- R1: After reset every location reads zero from both ports, including locations written before that reset; `usr_rdata` is zero and `bus_rvalid` is low out of reset.
- R2: Bus address `BASE + a + i*DEPTH` (i = 0 .. NSL-1, NSL = ceil(WIDTH/16)) maps to bits `[16i+15:16i]` of user location `a`; slice 0 holds the least significant bits.
- R3: A user write with `usr_we` high for one cycle updates all slices of that location at once; `usr_rdata` shows the word at `usr_addr` two clock cycles after the address is presented and still shows the previous result one cycle after.
- R4: A bus read request to an address inside the window raises `bus_rvalid` for exactly the following cycle, with `bus_rdata` carrying the addressed slice.
- R5: When WIDTH mod 16 is nonzero, bus writes to the top slice keep only its low WIDTH mod 16 bits, and reads of it return zero in the upper bits.
- R6: Bus writes outside `BASE .. BASE + NSL*DEPTH - 1` change nothing, and reads there leave `bus_rvalid` low.
- R7: If both ports write the same slice location in the same cycle, the user data is stored.
- R8: In user-to-host mode (`MODE_USER_TO_HOST`), bus writes are ignored and `usr_rdata` stays zero; user writes and bus reads work.
- R9: In host-to-user mode (`MODE_HOST_TO_USER`), user writes are ignored and `bus_rvalid` never rises; bus writes and user reads work.
- R10: User addresses at or above `DEPTH` are ignored for writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| usr_addr | input | AW = clog2(DEPTH) | User word address |
| usr_wdata | input | WIDTH | User write word |
| usr_we | input | 1 | User write enable |
| usr_rdata | output | WIDTH | User read word, two cycles after address |
| bus_addr | input | 16 | Bus register address |
| bus_wdata | input | 16 | Bus write data |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read request |
| bus_rdata | output | 16 | Bus read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Bus read data valid |

## Verification
The assertions assume that reset is held for at least one clock edge before any traffic. They also assume that all inputs carry known values once reset is released, because the written-location flags and the valid pipeline compare against their own previous cycle. The bench meets both assumptions. It holds reset for several cycles, drives every input to a defined level from time zero, and changes inputs only on the falling edge. This keeps each request stable across the rising edge that samples it. The bench never issues a read and a write to the same slice location in the same cycle, except in the deliberate collision case, so no check depends on read-during-write ordering.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [1:0] {
    MODE_BOTH         = 2'd0,
    MODE_USER_TO_HOST = 2'd1,
    MODE_HOST_TO_USER = 2'd2
  } bridge_mode_e;

  localparam int SLICE_W = 16;

  function automatic int slice_count(input int width);
    return (width + SLICE_W - 1) / SLICE_W;
  endfunction

endpackage

// File: rtl/bridge_slice.sv
module bridge_slice #(
  parameter int SW    = 16,
  parameter int DEPTH = 12,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          u_we,
  input  logic [AW-1:0] u_addr,
  input  logic [SW-1:0] u_wdata,
  output logic [SW-1:0] u_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [SW-1:0] b_wdata,
  output logic [SW-1:0] b_rdata
);

  logic [SW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] seen;
  logic [SW-1:0]    u_q, b_q;
  logic             u_seen_q, b_seen_q;
  logic             b_blocked;

  // user port wins a same-location collision
  assign b_blocked = u_we && (u_addr == b_addr);

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (b_we && !b_blocked) mem[b_addr] <= b_wdata;
    if (u_we)               mem[u_addr] <= u_wdata;
    u_q <= mem[u_addr];
    b_q <= mem[b_addr];
  end

  // per-location written flags give the zero-after-reset view
  always_ff @(posedge clk) begin
    if (rst) begin
      seen     <= '0;
      u_seen_q <= 1'b0;
      b_seen_q <= 1'b0;
    end else begin
      if (b_we) seen[b_addr] <= 1'b1;
      if (u_we) seen[u_addr] <= 1'b1;
      u_seen_q <= seen[u_addr];
      b_seen_q <= seen[b_addr];
    end
  end

  assign u_rdata = u_seen_q ? u_q : '0;
  assign b_rdata = b_seen_q ? b_q : '0;

  // R1: a written flag only clears through reset
  p_seen_hold_r1: assert property (@(posedge clk) disable iff (rst)
    ((seen & $past(seen)) == $past(seen)));

endmodule

// File: rtl/bridge_decode.sv
module bridge_decode #(
  parameter int BASE  = 256,
  parameter int DEPTH = 12,
  parameter int NSL   = 3,
  parameter int AW    = 4
) (
  input  logic [15:0]    addr,
  output logic [NSL-1:0] hit,
  output logic [AW-1:0]  loc
);

  logic [16:0] off;

  // below BASE the subtraction wraps high and matches no window
  assign off = {1'b0, addr} - 17'(BASE);

  for (genvar i = 0; i < NSL; i++) begin : g_win
    assign hit[i] = (off >= 17'(i * DEPTH)) && (off < 17'((i + 1) * DEPTH));
  end

  always_comb begin
    loc = '0;
    for (int i = 0; i < NSL; i++) begin
      if (hit[i]) loc = AW'(off - 17'(i * DEPTH));
    end
  end

endmodule

// File: rtl/bridge_mem.sv
module bridge_mem
  import bridge_pkg::*;
#(
  parameter int           WIDTH = 40,
  parameter int           DEPTH = 12,
  parameter int           BASE  = 256,
  parameter bridge_mode_e MODE  = MODE_BOTH,
  localparam int          AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    usr_addr,
  input  logic [WIDTH-1:0] usr_wdata,
  input  logic             usr_we,
  output logic [WIDTH-1:0] usr_rdata,
  input  logic [15:0]      bus_addr,
  input  logic [15:0]      bus_wdata,
  input  logic             bus_we,
  input  logic             bus_re,
  output logic [15:0]      bus_rdata,
  output logic             bus_rvalid
);

  localparam int NSL    = slice_count(WIDTH);
  localparam int TOPW   = WIDTH - SLICE_W * (NSL - 1);
  localparam int SIW    = (NSL > 1) ? $clog2(NSL) : 1;
  localparam bit USR_WR = (MODE != MODE_HOST_TO_USER);
  localparam bit USR_RD = (MODE != MODE_USER_TO_HOST);
  localparam bit BUS_WR = (MODE != MODE_USER_TO_HOST);
  localparam bit BUS_RD = (MODE != MODE_HOST_TO_USER);

  logic             usr_in, usr_in_q, u_we_ok;
  logic [AW-1:0]    u_idx;
  logic [NSL-1:0]   hit;
  logic [AW-1:0]    loc;
  logic             b_any;
  logic [SIW-1:0]   hit_idx, sidx_q;
  logic [WIDTH-1:0] usr_word;
  logic [15:0]      bus_words [NSL];

  assign usr_in  = (32'(usr_addr) < 32'(DEPTH));
  assign u_idx   = usr_in ? usr_addr : '0;
  assign u_we_ok = usr_we && usr_in && USR_WR;

  bridge_decode #(.BASE(BASE), .DEPTH(DEPTH), .NSL(NSL), .AW(AW)) u_dec (
    .addr(bus_addr),
    .hit (hit),
    .loc (loc)
  );

  assign b_any = |hit;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NSL; i++) begin
      if (hit[i]) hit_idx = SIW'(i);
    end
  end

  for (genvar i = 0; i < NSL; i++) begin : g_slice
    localparam int SW = (i == NSL - 1) ? TOPW : SLICE_W;
    logic [SW-1:0] u_rd, b_rd;

    bridge_slice #(.SW(SW), .DEPTH(DEPTH), .AW(AW)) u_slice (
      .clk    (clk),
      .rst    (rst),
      .u_we   (u_we_ok),
      .u_addr (u_idx),
      .u_wdata(usr_wdata[SLICE_W*i +: SW]),
      .u_rdata(u_rd),
      .b_we   (bus_we && hit[i] && BUS_WR),
      .b_addr (loc),
      .b_wdata(bus_wdata[SW-1:0]),
      .b_rdata(b_rd)
    );

    assign usr_word[SLICE_W*i +: SW] = u_rd;
    assign bus_words[i]              = 16'(b_rd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      usr_in_q   <= 1'b0;
      usr_rdata  <= '0;
      bus_rvalid <= 1'b0;
      sidx_q     <= '0;
    end else begin
      usr_in_q   <= usr_in;
      usr_rdata  <= (USR_RD && usr_in_q) ? usr_word : '0;
      bus_rvalid <= bus_re && b_any && BUS_RD;
      sidx_q     <= hit_idx;
    end
  end

  assign bus_rdata = bus_rvalid ? bus_words[sidx_q] : 16'h0000;

  // R2: a bus address selects at most one slice window
  p_one_slice_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));

  if (BUS_RD) begin : g_rd_chk
    // R4: an in-window read request yields valid on the next cycle
    p_rvalid_after_req_r4: assert property (@(posedge clk) disable iff (rst)
      (bus_re && b_any) |=> bus_rvalid);
  end

  // R6: no valid without an in-window request
  p_no_stray_rvalid_r6: assert property (@(posedge clk) disable iff (rst)
    !(bus_re && b_any) |=> !bus_rvalid);

  // R10: an out-of-range user address reads back as zero
  p_user_oob_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !usr_in |=> ##1 (usr_rdata == '0));

endmodule

// File: tb/bridge_mem_test.sv
module bridge_mem_test;
  import bridge_pkg::*;

  localparam int W    = 40;
  localparam int D    = 12;
  localparam int BASE = 256;
  localparam int AW   = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] usr_addr = '0;
  logic [W-1:0]  usr_wdata = '0;
  logic          usr_we = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;

  logic [W-1:0]  usr_rdata, u2h_urd, h2u_urd;
  logic [15:0]   bus_rdata, u2h_brd, h2u_brd;
  logic          bus_rvalid, u2h_bv, h2u_bv;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  bridge_mem #(.WIDTH(W), .DEPTH(D), .BASE(BASE), .MODE(MODE_BOTH)) uut (
    .clk(clk), .rst(rst), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
    .usr_we(usr_we), .usr_rdata(usr_rdata), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid));

  bridge_mem #(.WIDTH(W), .DEPTH(D), .BASE(BASE), .MODE(MODE_USER_TO_HOST)) uut_u2h (
    .clk(clk), .rst(rst), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
    .usr_we(usr_we), .usr_rdata(u2h_urd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(u2h_brd), .bus_rvalid(u2h_bv));

  bridge_mem #(.WIDTH(W), .DEPTH(D), .BASE(BASE), .MODE(MODE_HOST_TO_USER)) uut_h2u (
    .clk(clk), .rst(rst), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
    .usr_we(usr_we), .usr_rdata(h2u_urd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(h2u_brd), .bus_rvalid(h2u_bv));

  localparam logic [1:0] OP_UW = 2'd0, OP_UR = 2'd1, OP_BW = 2'd2, OP_BR = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [39:0] data;
    logic        ev;
    logic [39:0] exp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{OP_UW, 16'd3,     40'hA1B2C3D4E5, 1'b0, 40'h0},           // R3 write
    '{OP_UR, 16'd3,     40'h0,          1'b1, 40'hA1B2C3D4E5},  // R3 read back
    '{OP_BR, 16'h0103,  40'h0,          1'b1, 40'h000000D4E5},  // R2 R4 slice 0
    '{OP_BR, 16'h010F,  40'h0,          1'b1, 40'h000000B2C3},  // R2 slice 1
    '{OP_BR, 16'h011B,  40'h0,          1'b1, 40'h00000000A1},  // R2 R5 top slice
    '{OP_BW, 16'h0105,  40'h1234,       1'b0, 40'h0},
    '{OP_BW, 16'h0111,  40'h5678,       1'b0, 40'h0},
    '{OP_BW, 16'h011D,  40'hFF9A,       1'b0, 40'h0},           // R5 upper dropped
    '{OP_UR, 16'd5,     40'h0,          1'b1, 40'h9A56781234},  // R2 R5 assembled
    '{OP_BR, 16'h011D,  40'h0,          1'b1, 40'h000000009A},  // R5 upper zero
    '{OP_BW, 16'h00FF,  40'hBEEF,       1'b0, 40'h0},           // R6 below window
    '{OP_BR, 16'h00FF,  40'h0,          1'b0, 40'h0},           // R6 no valid
    '{OP_BW, 16'h0124,  40'h7777,       1'b0, 40'h0},           // R6 above window
    '{OP_BR, 16'h0124,  40'h0,          1'b0, 40'h0},           // R6 no valid
    '{OP_BR, 16'h0100,  40'h0,          1'b1, 40'h0},           // R1 R6 untouched
    '{OP_UR, 16'd11,    40'h0,          1'b1, 40'h0},           // R1 never written
    '{OP_BW, 16'h0123,  40'h4455,       1'b0, 40'h0},           // R2 last window addr
    '{OP_UR, 16'd11,    40'h0,          1'b1, 40'h5500000000},  // R2 R5
    '{OP_UW, 16'd11,    40'h0102030405, 1'b0, 40'h0},
    '{OP_BR, 16'h0117,  40'h0,          1'b1, 40'h0000000203}   // R2 R4
  };

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic user_write(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    usr_addr = a; usr_wdata = d; usr_we = 1'b1;
    @(negedge clk);
    usr_we = 1'b0;
  endtask

  task automatic user_read(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    usr_addr = a;
    @(negedge clk);
    @(negedge clk);
    d = usr_rdata;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic v, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    v = bus_rvalid;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [W-1:0] ud;
    logic [15:0]  bd;
    logic         bv;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 usr_rdata after reset", usr_rdata, '0);
    chk("R1 bus_rvalid after reset", 40'(bus_rvalid), 40'h0);
    user_read(4'd0, ud);
    chk("R1 user location 0 zero", ud, '0);

    for (int k = 0; k < NV; k++) begin
      case (VEC[k].op)
        OP_UW: user_write(VEC[k].addr[AW-1:0], VEC[k].data);
        OP_UR: begin
          user_read(VEC[k].addr[AW-1:0], ud);
          chk($sformatf("table[%0d] user data", k), ud, VEC[k].exp);
        end
        OP_BW: bus_write(VEC[k].addr, VEC[k].data[15:0]);
        default: begin
          bus_read(VEC[k].addr, bv, bd);
          chk($sformatf("table[%0d] bus valid", k), 40'(bv), 40'(VEC[k].ev));
          if (VEC[k].ev) chk($sformatf("table[%0d] bus data", k), 40'(bd), VEC[k].exp);
        end
      endcase
    end

    // R3: result appears two cycles after the address, not one
    user_read(4'd3, ud);
    @(negedge clk);
    usr_addr = 4'd5;
    @(negedge clk);
    chk("R3 previous word after one cycle", usr_rdata, 40'hA1B2C3D4E5);
    @(negedge clk);
    chk("R3 new word after two cycles", usr_rdata, 40'h9A56781234);

    // R7: same-cycle writes to slice 0 of location 2
    @(negedge clk);
    usr_addr = 4'd2; usr_wdata = 40'h1111222233; usr_we = 1'b1;
    bus_addr = 16'h0102; bus_wdata = 16'hAAAA; bus_we = 1'b1;
    @(negedge clk);
    usr_we = 1'b0; bus_we = 1'b0;
    bus_read(16'h0102, bv, bd);
    chk("R7 user wins slice 0", 40'(bd), 40'h2233);
    user_read(4'd2, ud);
    chk("R7 user word intact", ud, 40'h1111222233);

    // R8 R9: mode variants see the same traffic
    bus_write(16'h0106, 16'h3333);
    bus_read(16'h0106, bv, bd);
    chk("R4 both-mode bus read", 40'(bd), 40'h3333);
    chk("R8 user-to-host valid", 40'(u2h_bv), 40'h1);
    chk("R8 user-to-host ignores bus write", 40'(u2h_brd), 40'h0);
    chk("R9 host-to-user no valid", 40'(h2u_bv), 40'h0);
    user_write(4'd7, 40'h7777666655);
    user_read(4'd7, ud);
    chk("R3 both-mode user word", ud, 40'h7777666655);
    chk("R8 user-to-host user read zero", u2h_urd, '0);
    chk("R9 host-to-user ignores user write", h2u_urd, '0);
    bus_read(16'h0107, bv, bd);
    chk("R8 user-to-host sees user write", 40'(u2h_brd), 40'h6655);
    user_read(4'd6, ud);
    chk("R9 host-to-user sees bus write", h2u_urd, 40'h0000003333);

    // R10: addresses at or above DEPTH
    user_write(4'd13, 40'hFFFFFFFFFF);
    user_read(4'd13, ud);
    chk("R10 out-of-range reads zero", ud, '0);
    user_read(4'd0, ud);
    chk("R10 location 0 untouched", ud, '0);
    bus_read(16'h0101, bv, bd);
    chk("R10 location 1 untouched", 40'(bd), 40'h0);

    // R1: reset after traffic clears the view
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    user_read(4'd3, ud);
    chk("R1 user zero after second reset", ud, '0);
    bus_read(16'h0105, bv, bd);
    chk("R1 bus valid after second reset", 40'(bv), 40'h1);
    chk("R1 bus zero after second reset", 40'(bd), 40'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule